// File: doc/BRIEF.md
# NAND Command and Address Front-End

This block is the host-facing control side of a small-page NAND flash device with an 8-bit bus. The host writes bytes through `din` with a write strobe. A byte is a command when the command latch input is high and chip enable is active (low). It is an address byte when the address latch input is high and the command latch input is low. The block decodes the commands and packs the address bytes into one word. At the right address cycle it raises a single-cycle start pulse to the page array, carrying the operation kind, the address and the column. The page array is a separate block.

The block also serves two kinds of data read on its own. One is the identification sequence. The other is the status byte, which is taken as a snapshot when the status command arrives and then repeats on every read. Operations in this model complete at once, so the ready output stays high.

Top module: `nand_fe_top`

## Requirements
- R1: After `rst_n` is asserted (at power-up or mid-run), `dout` is 0x00, `op_start` is low, `op_kind` is 0 and `ready` is high. The command in force is plain read with a column pre-offset of zero, so three address bytes with no command before them start a read.
- R2: The read codes 0x00, 0x01 and 0x50 all select read. Their column pre-offsets are 0, 0x100 and PAGE_BYTES (512). The third address byte raises `op_start` for one cycle with `op_kind`=1 (read). `op_addr` is the packed address and `op_col` is address byte 0 plus the pre-offset.
- R3: Address bytes fill `op_addr` little-endian, one byte per accepted strobe. Bytes past ADDR_BYTES (4) are dropped. Every recognised command byte restarts the byte count at zero.
- R4: Code 0x80 followed by three address bytes gives `op_kind`=2 (program setup). Code 0x10 gives `op_kind`=3 (program) with the held address, but only if `wp_n` is high. With `wp_n` low, 0x10 gives no pulse.
- R5: Code 0x60, then N address bytes, then 0xD0 gives `op_kind`=4 (erase). `op_addr` is the low N bytes of the address shifted left by 8, and `op_col` is 0. With `wp_n` low, 0xD0 gives no pulse.
- R6: After 0x90 and one address byte, reads return 0xEC, 0x73, 0xA5 and 0xC0 in that order, then 0x00. A read before the address byte returns 0x00.
- R7: Code 0x70 captures the status byte {wp_n, 1, 000000}: bit 7 is unprotected, bit 6 is ready and bit 0 is error (always 0). Every later read returns that captured byte, whatever `wp_n` does afterwards, until a new command arrives.
- R8: Code 0xFF restores the command to read, clears the address, the byte count and the pre-offset, and ends the ID and status read modes.
- R9: A code outside the set is ignored. The read mode and the address byte count are left unchanged.
- R10: A read strobe while `ce_n` is high returns 0x00 and does not disturb the read mode.
- R11: `op_start` lasts exactly one cycle per triggering byte. While it is low, `op_kind`, `op_addr` and `op_col` are zero.
- R12: When a read strobe and a command byte arrive in the same cycle, the read is served by the mode that was in force before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch: a strobed byte is a command |
| ale | input | 1 | Address latch: a strobed byte is an address byte |
| wp_n | input | 1 | Write protect, active low |
| wr_en | input | 1 | Write strobe for `din` |
| din | input | 8 | Command or address byte |
| rd_en | input | 1 | Read strobe; `dout` updates on the next edge |
| dout | output | 8 | Read data (ID, status or zero) |
| ready | output | 1 | Ready/busy, held ready |
| op_start | output | 1 | One-cycle start pulse to the page array |
| op_kind | output | 3 | 0 none, 1 read, 2 program setup, 3 program, 4 erase |
| op_addr | output | 32 | Address for the operation |
| op_col | output | 10 | Column including the pre-offset |

## Verification
A read strobe and a command byte can land on the same edge. The bench provokes this by sending the status command in the same cycle as a data read while the ID sequence is active. It expects that read to return the next ID byte, and the following read to return the status snapshot. A second overlap occurs when a new `wp_n` level meets a status read. The bench changes `wp_n` on the same cycle as a read and expects the byte captured earlier.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_READ       = 3'd1,
    OP_PROG_SETUP = 3'd2,
    OP_PROGRAM    = 3'd3,
    OP_ERASE      = 3'd4
  } op_kind_e;

  typedef enum logic [1:0] {
    RM_IDLE   = 2'd0,
    RM_ID     = 2'd1,
    RM_STATUS = 2'd2
  } rd_mode_e;

  typedef enum logic [3:0] {
    CC_NONE, CC_READ, CC_PROG1, CC_PROG2, CC_ERASE1,
    CC_ERASE2, CC_STATUS, CC_ID, CC_RESET
  } cmd_class_e;

  typedef enum logic [1:0] {
    PO_ZERO  = 2'd0,
    PO_HALF  = 2'd1,
    PO_SPARE = 2'd2
  } preoff_e;

  typedef struct packed {
    logic       known;
    cmd_class_e cls;
    preoff_e    po;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [7:0] b);
    cmd_dec_t d;
    d = '{known: 1'b1, cls: CC_NONE, po: PO_ZERO};
    case (b)
      8'h00: d.cls = CC_READ;
      8'h01: begin d.cls = CC_READ; d.po = PO_HALF; end
      8'h50: begin d.cls = CC_READ; d.po = PO_SPARE; end
      8'h80: d.cls = CC_PROG1;
      8'h10: d.cls = CC_PROG2;
      8'h60: d.cls = CC_ERASE1;
      8'hD0: d.cls = CC_ERASE2;
      8'h70: d.cls = CC_STATUS;
      8'h90: d.cls = CC_ID;
      8'hFF: d.cls = CC_RESET;
      default: d.known = 1'b0;
    endcase
    return d;
  endfunction

  function automatic logic [7:0] status_byte(input logic wp_n);
    return {wp_n, 1'b1, 6'b000000};
  endfunction

  function automatic logic [15:0] col_sum(input logic [7:0] col, input preoff_e po,
                                          input logic [15:0] page_bytes);
    logic [15:0] base;
    case (po)
      PO_HALF:  base = 16'h0100;
      PO_SPARE: base = page_bytes;
      default:  base = 16'h0000;
    endcase
    return base + {8'h00, col};
  endfunction

endpackage

// File: rtl/nand_fe_decode.sv
module nand_fe_decode
  import nand_fe_pkg::*;
(
  input  logic [7:0] din,
  output cmd_dec_t   dec
);
  always_comb dec = decode_cmd(din);
endmodule

// File: rtl/nand_fe_addr.sv
module nand_fe_addr #(
  parameter int BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_cnt,
  input  logic                       clr_all,
  input  logic                       load,
  input  logic [7:0]                 din,
  output logic [8*BYTES-1:0]         addr_q,
  output logic [8*BYTES-1:0]         addr_nx,
  output logic [$clog2(BYTES+1)-1:0] cnt_q,
  output logic                       accept,
  output logic [$clog2(BYTES+1)-1:0] slot
);
  localparam int CW = $clog2(BYTES + 1);

  assign accept = load && (cnt_q < CW'(BYTES));
  assign slot   = cnt_q + CW'(1);

  always_comb begin
    addr_nx = addr_q;
    for (int i = 0; i < BYTES; i++) begin
      if (accept && cnt_q == CW'(i)) addr_nx[i*8 +: 8] = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_all) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_cnt) begin
      cnt_q  <= '0;
    end else if (accept) begin
      addr_q <= addr_nx;
      cnt_q  <= slot;
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BYTES));

  // R3
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cnt || clr_all) |=> (cnt_q == '0));

  // R8
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (addr_q == '0));
endmodule

// File: rtl/nand_fe_readout.sv
module nand_fe_readout
  import nand_fe_pkg::*;
#(
  parameter logic [7:0] MFR_CODE = 8'hEC,
  parameter logic [7:0] DEV_CODE = 8'h73,
  parameter logic [7:0] FILLER   = 8'hA5,
  parameter logic [7:0] ID_TAIL  = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_go,
  input  logic       rd_blk,
  input  logic       enter_status,
  input  logic       enter_id,
  input  logic       leave,
  input  logic       wp_n,
  output logic [7:0] dout
);
  localparam int          ID_LEN = 4;
  localparam logic [2:0]  ID_END = 3'(ID_LEN);

  rd_mode_e   mode_q;
  logic [2:0] ptr_q;
  logic [7:0] snap_q;

  function automatic logic [7:0] id_byte(input logic [2:0] p);
    case (p)
      3'd0:    return MFR_CODE;
      3'd1:    return DEV_CODE;
      3'd2:    return FILLER;
      3'd3:    return ID_TAIL;
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 8'h00;
    end else if (rd_blk) begin
      dout <= 8'h00;
    end else if (rd_go) begin
      case (mode_q)
        RM_ID:     dout <= id_byte(ptr_q);
        RM_STATUS: dout <= snap_q;
        default:   dout <= 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RM_IDLE;
      ptr_q  <= '0;
      snap_q <= 8'h00;
    end else begin
      if (enter_status) begin
        mode_q <= RM_STATUS;
        snap_q <= status_byte(wp_n);
      end else if (leave) begin
        mode_q <= RM_IDLE;
      end else if (enter_id) begin
        mode_q <= RM_ID;
      end
      if (enter_id)
        ptr_q <= '0;
      else if (rd_go && mode_q == RM_ID && ptr_q < ID_END)
        ptr_q <= ptr_q + 3'd1;
    end
  end

  // R10
  ce_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_blk |=> (dout == 8'h00));

  // R6
  id_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= ID_END);

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && mode_q == RM_STATUS) |=> (dout == $past(snap_q)));
endmodule

// File: rtl/nand_fe_top.sv
module nand_fe_top
  import nand_fe_pkg::*;
#(
  parameter int         PAGE_BYTES  = 512,
  parameter int         ADDR_BYTES  = 4,
  parameter int         START_CYCLE = 3,
  parameter logic [7:0] MFR_CODE    = 8'hEC,
  parameter logic [7:0] DEV_CODE    = 8'h73,
  parameter logic [7:0] FILLER      = 8'hA5
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   ce_n,
  input  logic                                   cle,
  input  logic                                   ale,
  input  logic                                   wp_n,
  input  logic                                   wr_en,
  input  logic [7:0]                             din,
  input  logic                                   rd_en,
  output logic [7:0]                             dout,
  output logic                                   ready,
  output logic                                   op_start,
  output logic [2:0]                             op_kind,
  output logic [8*ADDR_BYTES-1:0]                op_addr,
  output logic [$clog2(PAGE_BYTES+256)-1:0]      op_col
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int CW     = $clog2(ADDR_BYTES + 1);
  localparam int COL_W  = $clog2(PAGE_BYTES + 256);

  cmd_dec_t            dec;
  logic                cmd_go, cmd_take, adr_go;
  logic                adr_accept;
  logic [ADDR_W-1:0]   addr_q, addr_nx;
  logic [CW-1:0]       cnt_q, slot;
  cmd_class_e          cmd_q;
  preoff_e             po_q;
  op_kind_e            kind_q;
  logic                ready_q;
  logic                is_reset_cmd, start_on_addr;

  function automatic logic [ADDR_W-1:0] erase_addr(input logic [ADDR_W-1:0] a,
                                                    input logic [CW-1:0] n);
    logic [ADDR_W-1:0] m;
    m = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (CW'(i) < n) m[i*8 +: 8] = a[i*8 +: 8];
    end
    return m << 8;
  endfunction

  function automatic logic [COL_W-1:0] column(input logic [7:0] c, input preoff_e p);
    logic [15:0] s;
    s = col_sum(c, p, 16'(PAGE_BYTES));
    return s[COL_W-1:0];
  endfunction

  nand_fe_decode u_dec (.din(din), .dec(dec));

  assign cmd_go       = wr_en && !ce_n && cle;
  assign cmd_take     = cmd_go && dec.known;
  assign adr_go       = wr_en && !ce_n && ale && !cle;
  assign is_reset_cmd = cmd_take && dec.cls == CC_RESET;

  nand_fe_addr #(.BYTES(ADDR_BYTES)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_cnt (cmd_take),
    .clr_all (is_reset_cmd),
    .load    (adr_go),
    .din     (din),
    .addr_q  (addr_q),
    .addr_nx (addr_nx),
    .cnt_q   (cnt_q),
    .accept  (adr_accept),
    .slot    (slot)
  );

  assign start_on_addr = adr_accept && slot == CW'(START_CYCLE) &&
                         (cmd_q == CC_READ || cmd_q == CC_PROG1);

  nand_fe_readout #(
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE),
    .FILLER   (FILLER)
  ) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_go        (rd_en && !ce_n),
    .rd_blk       (rd_en && ce_n),
    .enter_status (cmd_take && dec.cls == CC_STATUS),
    .enter_id     (adr_accept && slot == CW'(1) && cmd_q == CC_ID),
    .leave        (cmd_take && dec.cls != CC_STATUS),
    .wp_n         (wp_n),
    .dout         (dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CC_READ;
      po_q  <= PO_ZERO;
    end else if (cmd_take) begin
      if (dec.cls == CC_RESET) begin
        cmd_q <= CC_READ;
        po_q  <= PO_ZERO;
      end else begin
        cmd_q <= dec.cls;
        if (dec.cls == CC_READ) po_q <= dec.po;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_start <= 1'b0;
      kind_q   <= OP_NONE;
      op_addr  <= '0;
      op_col   <= '0;
    end else begin
      op_start <= 1'b0;
      kind_q   <= OP_NONE;
      op_addr  <= '0;
      op_col   <= '0;
      if (cmd_take && dec.cls == CC_PROG2 && wp_n) begin
        op_start <= 1'b1;
        kind_q   <= OP_PROGRAM;
        op_addr  <= addr_q;
        op_col   <= column(addr_q[7:0], po_q);
      end else if (cmd_take && dec.cls == CC_ERASE2 && wp_n) begin
        op_start <= 1'b1;
        kind_q   <= OP_ERASE;
        op_addr  <= erase_addr(addr_q, cnt_q);
      end else if (start_on_addr) begin
        op_start <= 1'b1;
        kind_q   <= (cmd_q == CC_READ) ? OP_READ : OP_PROG_SETUP;
        op_addr  <= addr_nx;
        op_col   <= column(addr_nx[7:0], po_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b1;
    else        ready_q <= 1'b1;
  end

  assign ready   = ready_q;
  assign op_kind = kind_q;

  // R11
  idle_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_start |-> (kind_q == OP_NONE && op_addr == '0 && op_col == '0));

  // R4
  prog_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && kind_q == OP_PROGRAM) |-> $past(wp_n));

  // R5
  erase_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && kind_q == OP_ERASE) |-> ($past(wp_n) && op_col == '0));

  // R2
  read_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && kind_q == OP_READ) |-> ($past(cnt_q) == CW'(START_CYCLE - 1)));
endmodule

// File: tb/nand_fe_top_test.sv
module nand_fe_top_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, ce_n, cle, ale, wp_n, wr_en, rd_en;
  logic [7:0]  din, dout;
  logic        ready, op_start;
  logic [2:0]  op_kind;
  logic [31:0] op_addr;
  logic [9:0]  op_col;

  nand_fe_top uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
    .wr_en(wr_en), .din(din), .rd_en(rd_en), .dout(dout), .ready(ready),
    .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr), .op_col(op_col)
  );

  typedef struct packed {
    logic        ce_n, cle, ale, wp_n, wr, rd;
    logic [7:0]  din;
    logic        st;
    logic [2:0]  kind;
    logic [31:0] addr;
    logic [9:0]  col;
    logic        cd;
    logic [7:0]  dv;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk(logic c, logic cl, logic al, logic w, logic wr, logic rd,
                              logic [7:0] d, logic st, logic [2:0] k, logic [31:0] a,
                              logic [9:0] co, logic cd, logic [7:0] dv, logic [3:0] rq);
    return '{ce_n: c, cle: cl, ale: al, wp_n: w, wr: wr, rd: rd, din: d, st: st,
             kind: k, addr: a, col: co, cd: cd, dv: dv, req: rq};
  endfunction
  function automatic vec_t cv(logic [7:0] d, logic w, logic [3:0] rq);
    return mk(0, 1, 0, w, 1, 0, d, 0, 0, 0, 0, 0, 0, rq);
  endfunction
  function automatic vec_t cvs(logic [7:0] d, logic [2:0] k, logic [31:0] a, logic [9:0] co,
                               logic [3:0] rq);
    return mk(0, 1, 0, 1, 1, 0, d, 1, k, a, co, 0, 0, rq);
  endfunction
  function automatic vec_t av(logic [7:0] d, logic [3:0] rq);
    return mk(0, 0, 1, 1, 1, 0, d, 0, 0, 0, 0, 0, 0, rq);
  endfunction
  function automatic vec_t avs(logic [7:0] d, logic [2:0] k, logic [31:0] a, logic [9:0] co,
                               logic [3:0] rq);
    return mk(0, 0, 1, 1, 1, 0, d, 1, k, a, co, 0, 0, rq);
  endfunction
  function automatic vec_t rv(logic c, logic w, logic [7:0] dv, logic [3:0] rq);
    return mk(c, 0, 0, w, 0, 1, 8'h00, 0, 0, 0, 0, 1, dv, rq);
  endfunction

  // kinds: 1 read, 2 program setup, 3 program, 4 erase
  localparam int NV = 64;
  localparam vec_t VECS [NV] = '{
    av(8'h11, 3), av(8'h22, 3),                                   // R3 packing
    avs(8'h33, 1, 32'h0033_2211, 10'h011, 1),                     // R1 default read
    cv(8'h01, 1, 2), av(8'h05, 2), av(8'h06, 2),                  // R2 half offset
    avs(8'h07, 1, 32'h0007_0605, 10'h105, 2),
    cv(8'h50, 1, 2), av(8'h10, 2), av(8'h20, 2),                  // R2 spare offset
    avs(8'h30, 1, 32'h0030_2010, 10'h210, 2),
    cv(8'h00, 1, 2), av(8'hFF, 2), av(8'h01, 2),                  // R2 zero offset
    avs(8'h02, 1, 32'h0002_01FF, 10'h0FF, 2),
    av(8'h44, 3), av(8'h55, 3),                                   // R3 fifth byte dropped
    cvs(8'h10, 3, 32'h4402_01FF, 10'h0FF, 3),
    cv(8'h80, 1, 4), av(8'h00, 4), av(8'h12, 4),                  // R4 program
    avs(8'h34, 2, 32'h4434_1200, 10'h000, 4),
    cvs(8'h10, 3, 32'h4434_1200, 10'h000, 4),
    cv(8'h10, 0, 4),                                              // R4 protected
    cv(8'h60, 1, 5), av(8'h40, 5), av(8'h02, 5),                  // R5 erase
    cvs(8'hD0, 4, 32'h0002_4000, 10'h000, 5),
    cv(8'h60, 1, 5), cv(8'hD0, 0, 5),                             // R5 protected
    cv(8'h60, 1, 5), av(8'h7F, 5),
    cvs(8'hD0, 4, 32'h0000_7F00, 10'h000, 5),
    cv(8'h90, 1, 6), rv(0, 1, 8'h00, 6), av(8'h00, 6),            // R6 id
    rv(0, 1, 8'hEC, 6), rv(0, 1, 8'h73, 6), rv(0, 1, 8'hA5, 6),
    rv(0, 1, 8'hC0, 6), rv(0, 1, 8'h00, 6),
    cv(8'h70, 1, 7), rv(0, 1, 8'hC0, 7), rv(0, 0, 8'hC0, 7),      // R7 status snapshot
    cv(8'h70, 0, 7), rv(0, 0, 8'h40, 7),
    cv(8'h33, 0, 9), rv(0, 0, 8'h40, 9),                          // R9 unknown code
    cv(8'h70, 0, 10), rv(1, 0, 8'h00, 10), rv(0, 0, 8'h40, 10),   // R10 chip disabled
    cv(8'h90, 1, 12), av(8'h00, 12), rv(0, 1, 8'hEC, 12),         // R12 overlap
    mk(0, 1, 0, 0, 1, 1, 8'h70, 0, 0, 0, 0, 1, 8'h73, 12),
    rv(0, 0, 8'h40, 12),
    cv(8'h50, 1, 8), av(8'h01, 8), cv(8'hFF, 1, 8),               // R8 reset command
    rv(0, 1, 8'h00, 8), av(8'h0A, 8), av(8'h0B, 8),
    avs(8'h0C, 1, 32'h000C_0B0A, 10'h00A, 8),
    av(8'h0D, 11)                                                 // R11 pulse ended
  };

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    ce_n = v.ce_n; cle = v.cle; ale = v.ale; wp_n = v.wp_n;
    wr_en = v.wr; rd_en = v.rd; din = v.din;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic run_vec(vec_t v, int idx);
    string tag;
    apply(v);
    tag = $sformatf("R%0d vec %0d op", v.req, idx);
    if (v.st)
      chk(tag, {op_start, op_kind, op_addr[27:0]}, {1'b1, v.kind, v.addr[27:0]});
    else
      chk(tag, {31'd0, op_start}, 32'd0);
    if (v.st) chk({tag, " col/hi"}, {18'd0, op_col, op_addr[31:28]}, {18'd0, v.col, v.addr[31:28]});
    if (v.cd) chk($sformatf("R%0d vec %0d dout", v.req, idx), {24'd0, dout}, {24'd0, v.dv});
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; cle = 0; ale = 0; wp_n = 1; wr_en = 0; rd_en = 0; din = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {dout, op_start, op_kind, ready}, {8'h00, 1'b0, 3'd0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
    // R1 mid-run reset leaves status mode
    apply(cv(8'h70, 1, 1));
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset outputs", {dout, op_start, ready}, {8'h00, 1'b0, 1'b1});
    rst_n = 1'b1;
    apply(rv(0, 1, 8'h00, 1));
    chk("R1 read after reset", {24'd0, dout}, 32'd0);
    // R9 unknown code keeps the address byte count
    apply(av(8'h01, 9));
    apply(av(8'h02, 9));
    apply(cv(8'h33, 1, 9));
    apply(avs(8'h03, 1, 32'h0003_0201, 10'h001, 9));
    chk("R9 count kept op", {op_start, op_kind, op_addr[27:0]}, {1'b1, 3'd1, 28'h003_0201});
    chk("R9 count kept col", {22'd0, op_col}, {22'd0, 10'h001});
    // R11 pulse is single
    @(negedge clk);
    chk("R11 pulse single", {31'd0, op_start}, 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule